// File: doc/BRIEF.md
# DDR SDRAM Low-Power State Sequencer

This controller-side block moves a DDR SDRAM between normal operation and three low-power states: self refresh, precharge power-down and active power-down. The user side raises level requests to enter self refresh or power-down, or to leave either state. A flag chosen at power-down entry records that the DLL was switched off. A per-bank open-row vector decides which power-down flavour is entered, and a burst-busy input stalls any entry until the data transfer has finished.

The block owns the clock-enable pin and the four command strobes. Outside the low-power states, user commands go through a ready/valid port and reach the pins one cycle after acceptance. The port holds back every command while the memory sleeps. After an exit, it releases non-read commands after a short wait and reads after a longer one. The longer wait covers DLL relock after self refresh, or DLL re-enable after a DLL-off power-down, and for the DLL-off case a one-cycle DLL-enable request is raised. An exit-required flag asks the user to wake the device when refresh falls due during power-down.

Top module: `ddr_lp_seq`

## Requirements
- R1: After reset, CKE is high, the command pins {CS#,RAS#,CAS#,WE#} carry NOP (4'b0111) and the reported state is NORMAL (code 0).
- R2: In NORMAL, a user command accepted with cmdValid and cmdReady high appears on the command pins with CKE high one cycle later. In idle cycles the pins carry NOP.
- R3: A self-refresh request in NORMAL produces exactly one cycle of 4'b0001 with CKE low, and the state becomes SELFREF (code 1). If both requests are present, self refresh wins over power-down.
- R4: In SELFREF and both power-down states, CKE stays low, the pins are parked at DESELECT (4'b1111) after the entry cycle, and cmdReady is low, so user commands have no effect.
- R5: A power-down request in NORMAL drives CKE low with DESELECT. The state becomes precharge power-down (code 2) when no bankOpen bit is set, and active power-down (code 3) otherwise.
- R6: While burstActive is high, no entry request is taken and the state stays NORMAL.
- R7: On reqExit in a low-power state, the next cycle shows CKE high with DESELECT and state EXIT (code 4). After a power-down without DLL-off, any command is accepted in that same exit cycle, so it reaches the pins one clock after CKE rose.
- R8: After self-refresh exit, a non-read command is first ready XSNR_CYC-1 cycles after the CKE-rise cycle, and a READ (4'b0101) is first ready XSRD_CYC-1 cycles after it.
- R9: Leaving a power-down entered with dllOffReq high gives a one-cycle dllEnableReq pulse in the CKE-rise cycle. Non-reads are ready at once, and READ is first ready DLL_CYC-1 cycles later.
- R10: An entry request held during an exit wait leaves the state at EXIT until both waits end. The entry is then taken after one NORMAL cycle.
- R11: exitRequired follows refreshDue while in a power-down state and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqSelfRefresh | input | 1 | Level request to enter self refresh |
| reqPowerDown | input | 1 | Level request to enter power-down |
| reqExit | input | 1 | Level request to leave the low-power state |
| dllOffReq | input | 1 | DLL was disabled before this power-down (sampled at entry) |
| bankOpen | input | NUM_BANKS | Per-bank open-row status |
| burstActive | input | 1 | A read or write burst is in flight |
| refreshDue | input | 1 | Refresh interval has elapsed |
| cmdValid | input | 1 | User command valid |
| cmdCode | input | 4 | User command {CS#,RAS#,CAS#,WE#} |
| cmdReady | output | 1 | Command port can accept cmdCode |
| ddrCke | output | 1 | Clock enable pin |
| ddrCsN | output | 1 | Chip select, active low |
| ddrRasN | output | 1 | Row strobe, active low |
| ddrCasN | output | 1 | Column strobe, active low |
| ddrWeN | output | 1 | Write enable, active low |
| lpState | output | 3 | 0 NORMAL, 1 SELFREF, 2 precharge PD, 3 active PD, 4 EXIT |
| dllEnableReq | output | 1 | One-cycle request to re-enable the DLL |
| exitRequired | output | 1 | Refresh due while powered down |

## Verification
Entries are tried with all banks idle and with one open row, which separates the two power-down codes. They are also tried with a burst in flight and with both entry requests high, which checks stalling and priority. Exits are tried from a plain power-down, a DLL-off power-down and self refresh, with the ready line probed with a non-read and a READ code in every cycle, so that the short and long waits are measured separately. A power-down request held through a self-refresh exit shows that queued entries wait for the exit to finish, and commands offered while the memory sleeps must never reach the pins.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL  = 3'd0,
    ST_SELFREF = 3'd1,
    ST_PD_PRE  = 3'd2,
    ST_PD_ACT  = 3'd3,
    ST_EXIT    = 3'd4
  } lpsState_e;

  typedef struct packed {
    logic issueSr;
    logic issuePd;
    logic issueExit;
    logic passUser;
  } lpsStrobe_t;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] CMD_NOP   = 4'b0111;
  localparam logic [3:0] CMD_DESEL = 4'b1111;
  localparam logic [3:0] CMD_SREF  = 4'b0001;
  localparam logic [3:0] CMD_READ  = 4'b0101;
endpackage

// File: rtl/lps_ctrl.sv
module lps_ctrl
  import lps_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int XSRD_CYC  = 200,
  parameter int XSNR_CYC  = 10,
  parameter int DLL_CYC   = 200
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqSelfRefresh,
  input  logic                 reqPowerDown,
  input  logic                 reqExit,
  input  logic                 dllOffReq,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic                 burstActive,
  input  logic                 refreshDue,
  input  logic                 cmdValid,
  input  logic                 cmdIsRead,
  output logic                 cmdReady,
  output lpsStrobe_t           strobe,
  output lpsState_e            state,
  output logic                 dllEnableReq,
  output logic                 exitRequired
);
  localparam int MAX_AB = (XSRD_CYC > XSNR_CYC) ? XSRD_CYC : XSNR_CYC;
  localparam int MAX_C  = (MAX_AB > DLL_CYC) ? MAX_AB : DLL_CYC;
  localparam int CW     = $clog2(MAX_C + 1);

  logic [CW-1:0] cmdWait, readWait;
  logic          dllOffQ;
  logic          inPd, inLow;

  assign inPd  = (state == ST_PD_PRE) || (state == ST_PD_ACT);
  assign inLow = inPd || (state == ST_SELFREF);

  always_comb begin
    strobe.issueSr   = (state == ST_NORMAL) && reqSelfRefresh && !burstActive;
    strobe.issuePd   = (state == ST_NORMAL) && !reqSelfRefresh && reqPowerDown && !burstActive;
    strobe.issueExit = inLow && reqExit;
    unique case (state)
      ST_NORMAL: cmdReady = !(strobe.issueSr || strobe.issuePd);
      ST_EXIT:   cmdReady = (cmdWait == '0) && (!cmdIsRead || readWait == '0);
      default:   cmdReady = 1'b0;
    endcase
    strobe.passUser = cmdValid && cmdReady;
  end

  assign exitRequired = inPd && refreshDue;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_NORMAL;
      cmdWait      <= '0;
      readWait     <= '0;
      dllOffQ      <= 1'b0;
      dllEnableReq <= 1'b0;
    end else begin
      dllEnableReq <= strobe.issueExit && inPd && dllOffQ;
      unique case (state)
        ST_NORMAL: begin
          if (strobe.issueSr) begin
            state <= ST_SELFREF;
          end else if (strobe.issuePd) begin
            state   <= (|bankOpen) ? ST_PD_ACT : ST_PD_PRE;
            dllOffQ <= dllOffReq;
          end
        end
        ST_SELFREF: begin
          if (reqExit) begin
            state    <= ST_EXIT;
            cmdWait  <= CW'(XSNR_CYC - 1);
            readWait <= CW'(XSRD_CYC - 1);
          end
        end
        ST_PD_PRE, ST_PD_ACT: begin
          if (reqExit) begin
            state    <= ST_EXIT;
            cmdWait  <= '0;
            readWait <= dllOffQ ? CW'(DLL_CYC - 1) : '0;
          end
        end
        default: begin
          if (cmdWait != '0)  cmdWait  <= cmdWait - 1'b1;
          if (readWait != '0) readWait <= readWait - 1'b1;
          if (cmdWait == '0 && readWait == '0) begin
            state   <= ST_NORMAL;
            dllOffQ <= 1'b0;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lps_pins.sv
module lps_pins
  import lps_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  lpsStrobe_t strobe,
  input  logic [3:0] userCmd,
  output logic       ddrCke,
  output logic [3:0] ddrCmd
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ddrCke <= 1'b1;
      ddrCmd <= CMD_NOP;
    end else if (strobe.issueSr) begin
      ddrCke <= 1'b0;
      ddrCmd <= CMD_SREF;
    end else if (strobe.issuePd) begin
      ddrCke <= 1'b0;
      ddrCmd <= CMD_DESEL;
    end else if (strobe.issueExit) begin
      ddrCke <= 1'b1;
      ddrCmd <= CMD_DESEL;
    end else if (!ddrCke) begin
      ddrCmd <= CMD_DESEL;
    end else if (strobe.passUser) begin
      ddrCmd <= userCmd;
    end else begin
      ddrCmd <= CMD_NOP;
    end
  end
endmodule

// File: rtl/ddr_lp_seq.sv
module ddr_lp_seq
  import lps_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int XSRD_CYC  = 200,
  parameter int XSNR_CYC  = 10,
  parameter int DLL_CYC   = 200
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqSelfRefresh,
  input  logic                 reqPowerDown,
  input  logic                 reqExit,
  input  logic                 dllOffReq,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic                 burstActive,
  input  logic                 refreshDue,
  input  logic                 cmdValid,
  input  logic [3:0]           cmdCode,
  output logic                 cmdReady,
  output logic                 ddrCke,
  output logic                 ddrCsN,
  output logic                 ddrRasN,
  output logic                 ddrCasN,
  output logic                 ddrWeN,
  output logic [2:0]           lpState,
  output logic                 dllEnableReq,
  output logic                 exitRequired
);
  lpsStrobe_t strobe;
  lpsState_e  state;
  logic [3:0] ddrCmd;

  lps_ctrl #(
    .NUM_BANKS(NUM_BANKS), .XSRD_CYC(XSRD_CYC),
    .XSNR_CYC(XSNR_CYC), .DLL_CYC(DLL_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqSelfRefresh(reqSelfRefresh), .reqPowerDown(reqPowerDown),
    .reqExit(reqExit), .dllOffReq(dllOffReq), .bankOpen(bankOpen),
    .burstActive(burstActive), .refreshDue(refreshDue),
    .cmdValid(cmdValid), .cmdIsRead(cmdCode == CMD_READ),
    .cmdReady(cmdReady), .strobe(strobe), .state(state),
    .dllEnableReq(dllEnableReq), .exitRequired(exitRequired)
  );

  lps_pins u_pins (
    .clk(clk), .rstN(rstN), .strobe(strobe), .userCmd(cmdCode),
    .ddrCke(ddrCke), .ddrCmd(ddrCmd)
  );

  assign {ddrCsN, ddrRasN, ddrCasN, ddrWeN} = ddrCmd;
  assign lpState = state;
endmodule

// File: rtl/lps_checker.sv
module lps_checker #(
  parameter int XSRD_CYC = 200
) (
  input logic       clk,
  input logic       rstN,
  input logic       burstActive,
  input logic       cmdReady,
  input logic       ddrCke,
  input logic [3:0] pins,
  input logic [2:0] lpState,
  input logic       dllEnableReq,
  input logic       exitRequired
);
  logic [15:0] sinceRise;
  logic        ckePrev, lastSr, warm;
  logic        lowState;

  assign lowState = (lpState == 3'd1) || (lpState == 3'd2) || (lpState == 3'd3);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceRise <= 16'hFFFF;
      ckePrev   <= 1'b1;
      lastSr    <= 1'b0;
      warm      <= 1'b0;
    end else begin
      warm    <= 1'b1;
      ckePrev <= ddrCke;
      if (ddrCke && !ckePrev)     sinceRise <= 16'd1;
      else if (sinceRise != 16'hFFFF) sinceRise <= sinceRise + 16'd1;
      if (lpState == 3'd1)        lastSr <= 1'b1;
      else if (lowState)          lastSr <= 1'b0;
    end
  end

  AST_CKE_LOW_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    lowState |-> !ddrCke) else $error("cke high while asleep"); // R4
  AST_NO_READY_ASLEEP: assert property (@(posedge clk) disable iff (!rstN)
    lowState |-> !cmdReady) else $error("ready while asleep"); // R4
  AST_PD_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    (lpState == 3'd2 || lpState == 3'd3) |-> pins == 4'b1111) else $error("pins not parked"); // R5
  AST_SR_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    (warm && lpState == 3'd1 && $past(lpState) == 3'd1) |-> pins == 4'b1111) else $error("sr not parked"); // R4
  AST_BURST_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (lpState == 3'd0 && burstActive) |=> !lowState) else $error("entry during burst"); // R6
  AST_SR_READ_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (ddrCke && pins == 4'b0101 && lastSr) |-> sinceRise >= 16'(XSRD_CYC)) else $error("early read"); // R8
  AST_DLL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (warm && dllEnableReq) |-> (ddrCke && !ckePrev)) else $error("dll pulse misplaced"); // R9
  AST_EXIT_REQ: assert property (@(posedge clk) disable iff (!rstN)
    exitRequired |-> (lpState == 3'd2 || lpState == 3'd3)) else $error("exit flag outside pd"); // R11
endmodule

bind ddr_lp_seq lps_checker #(.XSRD_CYC(XSRD_CYC)) u_lps_checker (
  .clk(clk), .rstN(rstN), .burstActive(burstActive), .cmdReady(cmdReady),
  .ddrCke(ddrCke), .pins({ddrCsN, ddrRasN, ddrCasN, ddrWeN}),
  .lpState(lpState), .dllEnableReq(dllEnableReq), .exitRequired(exitRequired)
);

// File: tb/ddr_lp_seq_bench.sv
module ddr_lp_seq_bench;
  localparam int NB   = 4;
  localparam int XSRD = 200;
  localparam int XSNR = 10;
  localparam int DLLW = 200;
  localparam logic [3:0] NOP = 4'b0111, DES = 4'b1111, SREF = 4'b0001;
  localparam logic [3:0] RD = 4'b0101, ACT = 4'b0011;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqSelfRefresh = 0, reqPowerDown = 0, reqExit = 0, dllOffReq = 0;
  logic [NB-1:0] bankOpen = '0;
  logic burstActive = 0, refreshDue = 0, cmdValid = 0;
  logic [3:0] cmdCode = NOP;
  logic cmdReady, ddrCke, ddrCsN, ddrRasN, ddrCasN, ddrWeN, dllEnableReq, exitRequired;
  logic [2:0] lpState;
  logic [3:0] pins;

  int checks = 0, failures = 0;
  logic [3:0] expQ[$];
  bit done = 0;

  always #2 clk = ~clk;

  ddr_lp_seq #(.NUM_BANKS(NB), .XSRD_CYC(XSRD), .XSNR_CYC(XSNR), .DLL_CYC(DLLW)) u_ddr_lp_seq (
    .clk(clk), .rstN(rstN), .reqSelfRefresh(reqSelfRefresh), .reqPowerDown(reqPowerDown),
    .reqExit(reqExit), .dllOffReq(dllOffReq), .bankOpen(bankOpen), .burstActive(burstActive),
    .refreshDue(refreshDue), .cmdValid(cmdValid), .cmdCode(cmdCode), .cmdReady(cmdReady),
    .ddrCke(ddrCke), .ddrCsN(ddrCsN), .ddrRasN(ddrRasN), .ddrCasN(ddrCasN), .ddrWeN(ddrWeN),
    .lpState(lpState), .dllEnableReq(dllEnableReq), .exitRequired(exitRequired));

  assign pins = {ddrCsN, ddrRasN, ddrCasN, ddrWeN};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  // Monitor: every user command seen on the pins must match the scoreboard (R2)
  always @(negedge clk) begin
    if (rstN && ddrCke && pins != NOP && pins != DES) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R2 actual=%0d expected=none", pins);
      end else begin
        logic [3:0] e;
        e = expQ.pop_front();
        if (e != pins) begin
          failures++;
          $display("FAIL R2 actual=%0d expected=%0d", pins, e);
        end
      end
    end
  end

  // Driver: offer a command until accepted, pushing the expected pin value
  task automatic sendCmd(input logic [3:0] code);
    step;
    cmdValid = 1; cmdCode = code;
    #1;
    while (!cmdReady) begin step; #1; end
    expQ.push_back(code);
    @(posedge clk); #1;
    cmdValid = 0; cmdCode = NOP;
  endtask

  task automatic finishRun;
    chk("R2 scoreboard drained", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finishRun();
    end
  end

  initial begin
    int n, firstAct;
    repeat (3) step;
    rstN = 1;
    step;
    chk("R1 cke", ddrCke, 1); chk("R1 pins", pins, NOP); chk("R1 state", lpState, 0);

    sendCmd(ACT);
    step; step;
    chk("R2 idle nop", pins, NOP);

    // R6: burst stalls entry
    burstActive = 1; reqPowerDown = 1;
    repeat (3) step;
    chk("R6 state", lpState, 0); chk("R6 cke", ddrCke, 1);
    burstActive = 0;
    step;
    chk("R5 pre state", lpState, 2); chk("R5 cke", ddrCke, 0); chk("R5 pins", pins, DES);
    reqPowerDown = 0;

    // R4: commands ignored while asleep
    cmdValid = 1; cmdCode = RD; #1;
    chk("R4 ready", cmdReady, 0);
    step;
    chk("R4 pins", pins, DES); chk("R4 cke", ddrCke, 0);
    cmdValid = 0; cmdCode = NOP;

    // R11
    refreshDue = 1; #1; chk("R11 flag pd", exitRequired, 1);
    refreshDue = 0; #1; chk("R11 flag off", exitRequired, 0);

    // R7: plain power-down exit
    reqExit = 1; step; reqExit = 0;
    chk("R7 cke", ddrCke, 1); chk("R7 pins", pins, DES); chk("R7 state", lpState, 4);
    cmdCode = RD; #1; chk("R7 read ready", cmdReady, 1);
    cmdValid = 1; expQ.push_back(RD);
    @(posedge clk); #1; cmdValid = 0; cmdCode = NOP;
    step; chk("R7 back normal", lpState, 0);

    // R5: active power-down
    bankOpen = 4'b0100; reqPowerDown = 1;
    step; chk("R5 act state", lpState, 3);
    reqPowerDown = 0; bankOpen = '0;
    refreshDue = 1; #1; chk("R11 flag act", exitRequired, 1); refreshDue = 0;
    reqExit = 1; step; reqExit = 0;
    chk("R9 no pulse", dllEnableReq, 0);
    step;

    // R9: DLL-off power-down
    reqPowerDown = 1; dllOffReq = 1;
    step; chk("R9 entered", lpState, 2);
    reqPowerDown = 0; dllOffReq = 0;
    step;
    reqExit = 1; step; reqExit = 0;
    chk("R9 pulse", dllEnableReq, 1); chk("R9 cke", ddrCke, 1);
    cmdCode = ACT; #1; chk("R9 nonread ready", cmdReady, 1);
    cmdCode = RD; #1;
    n = 0;
    while (!cmdReady && n < 1000) begin step; #1; n++; end
    chk("R9 read wait", n, DLLW - 1);
    cmdValid = 1; expQ.push_back(RD);
    @(posedge clk); #1; cmdValid = 0; cmdCode = NOP;
    step; step;

    // R3: self refresh with priority
    reqSelfRefresh = 1; reqPowerDown = 1;
    step;
    chk("R3 pins", pins, SREF); chk("R3 cke", ddrCke, 0); chk("R3 state", lpState, 1);
    reqSelfRefresh = 0; reqPowerDown = 0;
    step; chk("R4 sr parked", pins, DES);
    cmdValid = 1; cmdCode = ACT;
    repeat (5) step;
    chk("R4 sr pins", pins, DES); chk("R4 sr cke", ddrCke, 0);
    cmdValid = 0;

    // R8 + R10: self-refresh exit with held power-down request
    reqExit = 1; step; reqExit = 0;
    reqPowerDown = 1;
    chk("R7 sr cke", ddrCke, 1); chk("R7 sr state", lpState, 4);
    n = 0; firstAct = -1;
    forever begin
      cmdCode = ACT; #1;
      if (cmdReady && firstAct < 0) firstAct = n;
      cmdCode = RD; #1;
      if (cmdReady || n >= 1000) break;
      step; n++;
    end
    chk("R8 nonread wait", firstAct, XSNR - 1);
    chk("R8 read wait", n, XSRD - 1);
    chk("R10 held in exit", lpState, 4);
    cmdCode = NOP;
    step; chk("R10 normal cycle", lpState, 0);
    step; chk("R10 queued entry", lpState, 2);
    reqPowerDown = 0;
    reqExit = 1; step; reqExit = 0;
    step; step;
    done = 1;
    finishRun();
  end
endmodule